// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker processes a linked chain of 64-byte buffer descriptors held in memory for one transfer direction. A start pulse loads a head pointer and a stop (tail) pointer. For each descriptor, the walker reads four words over a single-word memory port: the link word, the buffer address word, the control word and the status word. It then passes the buffer address, the byte length and the packet-boundary flags to an external data mover through a valid/ready command handshake. When the mover reports the bytes it moved, the walker writes a status word back into the descriptor. It then follows the link. It stops after the descriptor whose address matches the tail pointer.

The tail pointer may be rewritten at any time. While a walk is in progress, this lengthens the chain without a restart. Links may form a ring. Only the tail comparison ends a walk. The walker halts on any of four conditions: a memory response error, a descriptor that is already marked done, a zero-length descriptor, or a mover decode error. On a halt it pulses an error output and keeps the current pointer on the failing descriptor. A new start pulse resumes from the halted state.

States: IDLE, FETCH_NEXT, FETCH_BUF, FETCH_CTRL, FETCH_STAT, ISSUE, MOVE, WRITEBACK, HALT. The transitions are as follows:
- IDLE or HALT goes to FETCH_NEXT on start.
- Each FETCH state goes to the following one on a clean response, and to HALT on an error response.
- FETCH_STAT goes to ISSUE for a normal descriptor, to WRITEBACK for a zero length, and to HALT for a pre-done descriptor.
- ISSUE goes to MOVE on cmd_ready.
- MOVE goes to WRITEBACK on done_valid.
- WRITEBACK goes to IDLE at the tail, to FETCH_NEXT otherwise, and to HALT on any error.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, idle=1, halted=0, mem_req=0, cmd_valid=0, desc_done=0, err_pulse=0 and cur_ptr=0.
- R2: A start pulse in IDLE or HALT loads cur_ptr from head_ptr with bits 5:0 cleared. The walker then reads the descriptor words at offsets 0x00 (link), 0x08 (buffer), 0x18 (control) and 0x1C (status), in that order. Each is a single-word request, held with a stable address until mem_rvalid, and only one request is outstanding at a time.
- R3: The command carries cmd_addr = buffer word, cmd_len = control[22:0], cmd_sop = control[27] and cmd_eop = control[26]. It stays valid and stable until cmd_ready.
- R4: After done_valid, the walker writes to offset 0x1C a status word with bit 31 set and bits 22:0 equal to done_bytes. No other memory request and no command occurs until that write is answered.
- R5: desc_done pulses for exactly one cycle per successfully written-back descriptor, in the cycle after the write response.
- R6: After the write-back of the descriptor whose address equals the tail pointer, the walker returns to IDLE (idle=1), with cur_ptr left on that descriptor.
- R7: A tail_load while walking replaces the tail, and the walk continues past the old tail to the new one.
- R8: Links are followed through any wraparound of a ring, and link bits 5:0 are ignored.
- R9: If a fetched status word already has bit 31 set, the walker halts: err_pulse is raised, no command is issued, nothing is written and cur_ptr stays on that descriptor.
- R10: A mem_rerr response halts the walker with an err_pulse, and cur_ptr stays on the failing descriptor.
- R11: A control length of 0 issues no command. The walker writes status 0x9000_0000 (bits 31 and 28) and halts with an err_pulse and no desc_done.
- R12: A done_err from the mover gives status bit 31, bit 30 and the byte count. The walker then halts with an err_pulse and no desc_done.
- R13: A tail_load while idle starts no memory request and leaves the walker idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted in IDLE or HALT) |
| head_ptr | input | ADDR_W | First descriptor address |
| tail_ptr | input | ADDR_W | Last descriptor address |
| tail_load | input | 1 | Replace the tail pointer |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response for the outstanding request |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 1 | Response carries an error |
| cmd_valid | output | 1 | Mover command valid |
| cmd_ready | input | 1 | Mover accepts command |
| cmd_addr | output | ADDR_W | Buffer address |
| cmd_len | output | LEN_W | Buffer length in bytes |
| cmd_sop | output | 1 | Start of packet |
| cmd_eop | output | 1 | End of packet |
| done_valid | input | 1 | Mover finished |
| done_bytes | input | LEN_W | Bytes actually moved |
| done_err | input | 1 | Mover decode error |
| idle | output | 1 | Not walking (IDLE or HALT) |
| halted | output | 1 | Stopped on an error |
| desc_done | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle error pulse |
| cur_ptr | output | ADDR_W | Descriptor being processed |

## Verification
The test chains are of three kinds. A straight three-descriptor chain confirms the fetch order and the mapping of control fields to the command. A chain whose tail is moved mid-walk separates extension from a premature stop. A ring started in its middle, with junk in the low link bits, separates tail-based stopping from stopping on wraparound. Single-descriptor runs cover the remaining behaviour: a short byte count, a pre-done status word, a zero length and a mover decode error. Each of these shows a distinct status word or halt signature. A response error injected on a buffer word separates a frozen pointer from a pointer that advanced. A tail write while idle shows that the walker does not start on its own.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_NEXT,
        ST_FETCH_BUF,
        ST_FETCH_CTRL,
        ST_FETCH_STAT,
        ST_ISSUE,
        ST_MOVE,
        ST_WRITEBACK,
        ST_HALT
    } walk_state_e;

    typedef enum logic [1:0] {
        WB_OK,
        WB_DECERR,
        WB_ZERO
    } wb_kind_e;

    // word offsets inside one descriptor
    localparam logic [5:0] OFF_NEXT = 6'h00;
    localparam logic [5:0] OFF_BUF  = 6'h08;
    localparam logic [5:0] OFF_CTRL = 6'h18;
    localparam logic [5:0] OFF_STAT = 6'h1C;

    // control word fields
    localparam int CTRL_SOP_BIT = 27;
    localparam int CTRL_EOP_BIT = 26;

    // status word fields
    localparam int STAT_DONE_BIT   = 31;
    localparam int STAT_DECERR_BIT = 30;
    localparam int STAT_INTERR_BIT = 28;

    localparam int DEF_LEN_W = 23;

endpackage

// File: rtl/sgw_mem_port.sv
module sgw_mem_port #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_we,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [31:0]       issue_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              resp_err
);

    // One request in flight; it is held until its response arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (mem_req) begin
            if (mem_rvalid) begin
                mem_req <= 1'b0;
                mem_we  <= 1'b0;
            end
        end else if (issue) begin
            mem_req   <= 1'b1;
            mem_we    <= issue_we;
            mem_addr  <= issue_addr;
            mem_wdata <= issue_wdata;
        end
    end

    assign resp_valid = mem_req && mem_rvalid;
    assign resp_rdata = mem_rdata;
    assign resp_err   = mem_rerr;

endmodule

// File: rtl/sgw_status_pack.sv
module sgw_status_pack
    import sgw_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  wb_kind_e         kind,
    input  logic [LEN_W-1:0] bytes_moved,
    output logic [31:0]      status_word
);

    always_comb begin
        status_word                = '0;
        status_word[STAT_DONE_BIT] = 1'b1;
        status_word[LEN_W-1:0]     = bytes_moved;
        unique case (kind)
            WB_OK:     ;
            WB_DECERR: status_word[STAT_DECERR_BIT] = 1'b1;
            WB_ZERO:   status_word[STAT_INTERR_BIT] = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = DEF_LEN_W,
    parameter int ALIGN_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] head_ptr,
    input  logic [ADDR_W-1:0] tail_ptr,
    input  logic              tail_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_sop,
    output logic              cmd_eop,
    input  logic              done_valid,
    input  logic [LEN_W-1:0]  done_bytes,
    input  logic              done_err,
    output logic              idle,
    output logic              halted,
    output logic              desc_done,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] cur_ptr
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK =
        {{(ADDR_W-ALIGN_LOG2){1'b1}}, {ALIGN_LOG2{1'b0}}};

    walk_state_e       state, state_d;
    logic              acc_sent;
    logic              acc_issue;
    logic              acc_we;
    logic [5:0]        acc_off;
    logic [ADDR_W-1:0] tail_q;
    logic [ADDR_W-1:0] next_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  len_q;
    logic              sop_q;
    logic              eop_q;
    logic [LEN_W-1:0]  moved_q;
    wb_kind_e          kind_q;
    logic [31:0]       wb_word;
    logic              resp_valid;
    logic [31:0]       resp_rdata;
    logic              resp_err;
    logic              at_rest;
    logic              accept_start;
    logic              len_zero;

    assign at_rest      = (state == ST_IDLE) || (state == ST_HALT);
    assign accept_start = at_rest && start;
    assign len_zero     = (len_q == '0);

    sgw_mem_port #(.ADDR_W(ADDR_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (acc_issue),
        .issue_we    (acc_we),
        .issue_addr  (cur_ptr | ADDR_W'(acc_off)),
        .issue_wdata (wb_word),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .mem_rerr    (mem_rerr),
        .resp_valid  (resp_valid),
        .resp_rdata  (resp_rdata),
        .resp_err    (resp_err)
    );

    sgw_status_pack #(.LEN_W(LEN_W)) u_pack (
        .kind        (kind_q),
        .bytes_moved (moved_q),
        .status_word (wb_word)
    );

    // next-state logic
    always_comb begin
        state_d   = state;
        acc_issue = 1'b0;
        acc_we    = 1'b0;
        acc_off   = OFF_NEXT;
        unique case (state)
            ST_IDLE, ST_HALT: begin
                if (start) state_d = ST_FETCH_NEXT;
            end
            ST_FETCH_NEXT: begin
                acc_off   = OFF_NEXT;
                acc_issue = !acc_sent;
                if (resp_valid) state_d = resp_err ? ST_HALT : ST_FETCH_BUF;
            end
            ST_FETCH_BUF: begin
                acc_off   = OFF_BUF;
                acc_issue = !acc_sent;
                if (resp_valid) state_d = resp_err ? ST_HALT : ST_FETCH_CTRL;
            end
            ST_FETCH_CTRL: begin
                acc_off   = OFF_CTRL;
                acc_issue = !acc_sent;
                if (resp_valid) state_d = resp_err ? ST_HALT : ST_FETCH_STAT;
            end
            ST_FETCH_STAT: begin
                acc_off   = OFF_STAT;
                acc_issue = !acc_sent;
                if (resp_valid) begin
                    if (resp_err || resp_rdata[STAT_DONE_BIT]) state_d = ST_HALT;
                    else if (len_zero)                         state_d = ST_WRITEBACK;
                    else                                       state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) state_d = ST_MOVE;
            end
            ST_MOVE: begin
                if (done_valid) state_d = ST_WRITEBACK;
            end
            ST_WRITEBACK: begin
                acc_off   = OFF_STAT;
                acc_we    = 1'b1;
                acc_issue = !acc_sent;
                if (resp_valid) begin
                    if (resp_err || kind_q != WB_OK) state_d = ST_HALT;
                    else if (cur_ptr == tail_q)      state_d = ST_IDLE;
                    else                             state_d = ST_FETCH_NEXT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_sent <= 1'b0;
            cur_ptr  <= '0;
            tail_q   <= '0;
            next_q   <= '0;
            buf_q    <= '0;
            len_q    <= '0;
            sop_q    <= 1'b0;
            eop_q    <= 1'b0;
            moved_q  <= '0;
            kind_q   <= WB_OK;
        end else begin
            if (acc_issue)       acc_sent <= 1'b1;
            else if (resp_valid) acc_sent <= 1'b0;

            if (accept_start) cur_ptr <= head_ptr & ALIGN_MASK;
            if (accept_start || tail_load) tail_q <= tail_ptr & ALIGN_MASK;

            if (resp_valid && !resp_err) begin
                unique case (state)
                    ST_FETCH_NEXT: next_q <= ADDR_W'(resp_rdata) & ALIGN_MASK;
                    ST_FETCH_BUF:  buf_q  <= ADDR_W'(resp_rdata);
                    ST_FETCH_CTRL: begin
                        len_q <= resp_rdata[LEN_W-1:0];
                        sop_q <= resp_rdata[CTRL_SOP_BIT];
                        eop_q <= resp_rdata[CTRL_EOP_BIT];
                    end
                    ST_FETCH_STAT: begin
                        if (len_zero) begin
                            kind_q  <= WB_ZERO;
                            moved_q <= '0;
                        end
                    end
                    ST_WRITEBACK: begin
                        if (kind_q == WB_OK && cur_ptr != tail_q) cur_ptr <= next_q;
                    end
                    default: ;
                endcase
            end

            if (state == ST_MOVE && done_valid) begin
                moved_q <= done_bytes;
                kind_q  <= done_err ? WB_DECERR : WB_OK;
            end
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_done <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            desc_done <= (state == ST_WRITEBACK) && resp_valid && !resp_err && (kind_q == WB_OK);
            err_pulse <= (state != ST_HALT) && (state_d == ST_HALT);
        end
    end

    assign idle      = at_rest;
    assign halted    = (state == ST_HALT);
    assign cmd_valid = (state == ST_ISSUE);
    assign cmd_addr  = buf_q;
    assign cmd_len   = len_q;
    assign cmd_sop   = sop_q;
    assign cmd_eop   = eop_q;

endmodule

// File: rtl/sgw_walker_checker.sv
module sgw_walker_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              desc_done,
    input logic              err_pulse,
    input logic              idle
);

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    assert_word_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[5:0] == 6'h00 || mem_addr[5:0] == 6'h08 ||
                     mem_addr[5:0] == 6'h18 || mem_addr[5:0] == 6'h1C));

    assert_cmd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_len));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cmd_valid));

    assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |-> $past(mem_rvalid && mem_we));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req && !cmd_valid);

    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_done && err_pulse));

endmodule

bind sg_chain_walker sgw_walker_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_len    (cmd_len),
    .desc_done  (desc_done),
    .err_pulse  (err_pulse),
    .idle       (idle)
);

// File: tb/sg_chain_walker_tb_top.sv
module sg_chain_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] head_ptr = '0;
    logic [31:0] tail_ptr = '0;
    logic        tail_load = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [22:0] cmd_len;
    logic        cmd_sop, cmd_eop;
    logic        done_valid = 1'b0;
    logic [22:0] done_bytes = '0;
    logic        done_err = 1'b0;
    logic        idle, halted, desc_done, err_pulse;
    logic [31:0] cur_ptr;

    always #2.5 clk = ~clk;

    sg_chain_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
        .tail_ptr(tail_ptr), .tail_load(tail_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
        .done_valid(done_valid), .done_bytes(done_bytes), .done_err(done_err),
        .idle(idle), .halted(halted), .desc_done(desc_done), .err_pulse(err_pulse),
        .cur_ptr(cur_ptr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:255];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] acc_log [0:63];
    int          acc_cnt = 0;

    logic [31:0] cmd_log_addr [0:31];
    logic [22:0] cmd_log_len  [0:31];
    logic        cmd_log_sop  [0:31];
    logic        cmd_log_eop  [0:31];
    int          cmd_cnt = 0;
    int          mv_cnt = 0;
    bit          short_en = 1'b0;
    logic [22:0] short_bytes = '0;
    logic [31:0] decerr_buf = 32'hFFFF_FFFF;
    int          done_cnt = 0;
    int          errp_cnt = 0;

    // memory responder
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end else if (mem_req) begin
            acc_log[acc_cnt % 64] = mem_addr;
            acc_cnt++;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[9:2]];
            mem_rerr   = (mem_addr == err_addr);
            mem_rvalid = 1'b1;
        end
    end

    // data mover model
    always @(negedge clk) begin
        done_valid = 1'b0;
        done_err   = 1'b0;
        if (cmd_ready) begin
            cmd_ready = 1'b0;
        end else if (mv_cnt > 0) begin
            mv_cnt--;
            if (mv_cnt == 0) begin
                done_valid = 1'b1;
                done_bytes = short_en ? short_bytes : cmd_log_len[(cmd_cnt-1) % 32];
                done_err   = (cmd_log_addr[(cmd_cnt-1) % 32] == decerr_buf);
            end
        end else if (cmd_valid) begin
            cmd_log_addr[cmd_cnt % 32] = cmd_addr;
            cmd_log_len[cmd_cnt % 32]  = cmd_len;
            cmd_log_sop[cmd_cnt % 32]  = cmd_sop;
            cmd_log_eop[cmd_cnt % 32]  = cmd_eop;
            cmd_cnt++;
            cmd_ready = 1'b1;
            mv_cnt    = 3;
        end
    end

    always @(negedge clk) begin
        if (desc_done) done_cnt++;
        if (err_pulse) errp_cnt++;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] dptr(input int idx);
        return 32'(idx * 64);
    endfunction

    task automatic set_desc(input int idx, input logic [31:0] nxt, input logic [31:0] bufa,
                            input logic [31:0] ctrl, input logic [31:0] stat);
        for (int w = 0; w < 16; w++) mem[idx*16 + w] = '0;
        mem[idx*16 + 0] = nxt;
        mem[idx*16 + 2] = bufa;
        mem[idx*16 + 6] = ctrl;
        mem[idx*16 + 7] = stat;
    endtask

    function automatic logic [31:0] stat_of(input int idx);
        return mem[idx*16 + 7];
    endfunction

    task automatic do_start(input logic [31:0] h, input logic [31:0] t);
        @(negedge clk);
        head_ptr = h;
        tail_ptr = t;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (idle) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(idle == 1'b1 && halted == 1'b0, "R1 idle/halted", {30'd0, idle, halted}, 32'h2);
        chk(!mem_req && !cmd_valid && !desc_done && !err_pulse, "R1 quiet outputs",
            {28'd0, mem_req, cmd_valid, desc_done, err_pulse}, 32'h0);
        chk(cur_ptr == 32'h0, "R1 cur_ptr", cur_ptr, 32'h0);
    endtask

    task automatic t_basic();
        int a0 = acc_cnt, c0 = cmd_cnt, d0 = done_cnt;
        set_desc(0, dptr(1), 32'h1000, 32'h0800_0064, 32'h0);
        set_desc(1, dptr(2), 32'h2000, 32'h0000_0032, 32'h0);
        set_desc(2, dptr(9), 32'h3000, 32'h0400_001E, 32'h0);
        do_start(dptr(0) | 32'h11, dptr(2));
        wait_idle();
        chk(acc_log[a0] == 32'h00 && acc_log[a0+1] == 32'h08 && acc_log[a0+2] == 32'h18 &&
            acc_log[a0+3] == 32'h1C, "R2 fetch order", acc_log[a0+2], 32'h18);
        chk(acc_log[a0+4] == 32'h1C, "R4 writeback address", acc_log[a0+4], 32'h1C);
        chk(cmd_cnt - c0 == 3, "R3 command count", 32'(cmd_cnt - c0), 32'd3);
        chk(cmd_log_addr[c0%32] == 32'h1000 && cmd_log_len[c0%32] == 23'd100 &&
            cmd_log_sop[c0%32] && !cmd_log_eop[c0%32], "R3 first command",
            32'(cmd_log_len[c0%32]), 32'd100);
        chk(cmd_log_addr[(c0+1)%32] == 32'h2000 && !cmd_log_sop[(c0+1)%32] &&
            !cmd_log_eop[(c0+1)%32], "R3 middle command", cmd_log_addr[(c0+1)%32], 32'h2000);
        chk(cmd_log_len[(c0+2)%32] == 23'd30 && cmd_log_eop[(c0+2)%32] &&
            !cmd_log_sop[(c0+2)%32], "R3 last command", 32'(cmd_log_len[(c0+2)%32]), 32'd30);
        chk(stat_of(0) == 32'h8000_0064, "R4 status 0", stat_of(0), 32'h8000_0064);
        chk(stat_of(2) == 32'h8000_001E, "R4 status 2", stat_of(2), 32'h8000_001E);
        chk(done_cnt - d0 == 3, "R5 completion pulses", 32'(done_cnt - d0), 32'd3);
        chk(idle && !halted && cur_ptr == dptr(2), "R6 stop at tail", cur_ptr, dptr(2));
    endtask

    task automatic t_short();
        int d0 = done_cnt;
        set_desc(4, dptr(0), 32'h4000, 32'h0C00_00C8, 32'h0);
        short_en = 1'b1;
        short_bytes = 23'd77;
        do_start(dptr(4), dptr(4));
        wait_idle();
        short_en = 1'b0;
        chk(stat_of(4) == 32'h8000_004D, "R4 short byte count", stat_of(4), 32'h8000_004D);
        chk(done_cnt - d0 == 1, "R5 single pulse", 32'(done_cnt - d0), 32'd1);
    endtask

    task automatic t_extend();
        int d0 = done_cnt;
        set_desc(0, dptr(1), 32'h1000, 32'h10, 32'h0);
        set_desc(1, dptr(2), 32'h1100, 32'h10, 32'h0);
        set_desc(2, dptr(3), 32'h1200, 32'h10, 32'h0);
        set_desc(3, dptr(0), 32'h1300, 32'h10, 32'h0);
        do_start(dptr(0), dptr(1));
        for (int i = 0; i < 500; i++) begin
            if (cur_ptr == dptr(1)) break;
            @(negedge clk);
        end
        tail_ptr  = dptr(3);
        tail_load = 1'b1;
        @(negedge clk);
        tail_load = 1'b0;
        wait_idle();
        chk(done_cnt - d0 == 4, "R7 extended walk count", 32'(done_cnt - d0), 32'd4);
        chk(cur_ptr == dptr(3) && stat_of(3) == 32'h8000_0010, "R7 new tail reached", cur_ptr, dptr(3));
    endtask

    task automatic t_ring();
        int c0 = cmd_cnt;
        set_desc(8,  dptr(9),  32'h8000, 32'h20, 32'h0);
        set_desc(9,  dptr(10), 32'h9000, 32'h20, 32'h0);
        set_desc(10, dptr(11), 32'hA000, 32'h20, 32'h0);
        set_desc(11, dptr(8) | 32'h5, 32'hB000, 32'h20, 32'h0);
        do_start(dptr(10), dptr(9));
        wait_idle();
        chk(cmd_cnt - c0 == 4, "R8 ring count", 32'(cmd_cnt - c0), 32'd4);
        chk(cmd_log_addr[c0%32] == 32'hA000 && cmd_log_addr[(c0+1)%32] == 32'hB000 &&
            cmd_log_addr[(c0+2)%32] == 32'h8000 && cmd_log_addr[(c0+3)%32] == 32'h9000,
            "R8 ring order", cmd_log_addr[(c0+2)%32], 32'h8000);
        chk(cur_ptr == dptr(9) && idle && !halted, "R8 ring stop", cur_ptr, dptr(9));
    endtask

    task automatic t_idle_tail();
        int a0 = acc_cnt;
        @(negedge clk);
        tail_ptr  = dptr(3);
        tail_load = 1'b1;
        @(negedge clk);
        tail_load = 1'b0;
        repeat (20) @(negedge clk);
        chk(acc_cnt == a0 && idle, "R13 tail load while idle", 32'(acc_cnt - a0), 32'd0);
    endtask

    task automatic t_predone();
        int c0 = cmd_cnt, e0 = errp_cnt, a0 = acc_cnt;
        set_desc(5, dptr(0), 32'h5000, 32'h40, 32'h8000_0123);
        do_start(dptr(5), dptr(5));
        wait_idle();
        chk(halted && errp_cnt - e0 == 1, "R9 halt with error", 32'(errp_cnt - e0), 32'd1);
        chk(cmd_cnt == c0 && acc_cnt - a0 == 4, "R9 no command no write",
            32'(acc_cnt - a0), 32'd4);
        chk(cur_ptr == dptr(5) && stat_of(5) == 32'h8000_0123, "R9 pointer and status kept",
            stat_of(5), 32'h8000_0123);
    endtask

    task automatic t_memerr();
        int d0 = done_cnt, e0 = errp_cnt;
        set_desc(0, dptr(1), 32'h1000, 32'h10, 32'h0);
        set_desc(1, dptr(2), 32'h1100, 32'h10, 32'h0);
        err_addr = dptr(1) + 32'h8;
        do_start(dptr(0), dptr(1));
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        chk(halted && errp_cnt - e0 == 1 && done_cnt - d0 == 1, "R10 halt on response error",
            32'(errp_cnt - e0), 32'd1);
        chk(cur_ptr == dptr(1), "R10 pointer frozen", cur_ptr, dptr(1));
    endtask

    task automatic t_zero();
        int c0 = cmd_cnt, d0 = done_cnt, e0 = errp_cnt;
        set_desc(6, dptr(0), 32'h6000, 32'h0C00_0000, 32'h0);
        do_start(dptr(6), dptr(6));
        wait_idle();
        chk(stat_of(6) == 32'h9000_0000, "R11 zero length status", stat_of(6), 32'h9000_0000);
        chk(cmd_cnt == c0 && done_cnt == d0 && halted && errp_cnt - e0 == 1,
            "R11 no command, halted", 32'(cmd_cnt - c0), 32'd0);
    endtask

    task automatic t_decerr();
        int d0 = done_cnt, e0 = errp_cnt;
        set_desc(7, dptr(0), 32'h7700, 32'h0000_0055, 32'h0);
        decerr_buf = 32'h7700;
        do_start(dptr(7), dptr(7));
        wait_idle();
        decerr_buf = 32'hFFFF_FFFF;
        chk(stat_of(7) == 32'hC000_0055, "R12 decode error status", stat_of(7), 32'hC000_0055);
        chk(halted && done_cnt == d0 && errp_cnt - e0 == 1, "R12 halted without completion",
            32'(done_cnt - d0), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_short();
        t_extend();
        t_ring();
        t_idle_tail();
        t_predone();
        t_memerr();
        t_zero();
        t_decerr();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule